// File: doc/BRIEF.md
# Power-Management Register File with Interrupts

This block is the register side of a power-management companion device. A serial bus slave port that sits outside the block decodes each frame into one access: a 5-bit register index, a write flag, 16 bits of write data and a one-cycle strobe. The register file answers a read with the addressed value one cycle later. A write applies the register's own rule. These rules are not uniform:
- The interrupt status register toggles the bits written to it.
- The sampling-control register clears the bits written to it.
- A write to the converter select register also records a conversion-done interrupt.
- A zero written to the watchdog register, while an enable bit in the first control register is set, raises a system shutdown request.

The block drives one level interrupt output. It is high while any unmasked status bit is set. A power-key input pair also feeds the interrupt logic and a key-level bit in the status register. The converter results are fixed values per channel, because the block contains no real converter. The clock, alarm and audio register slots exist but read as zero. Indices that are not decoded at all pulse an error flag.

Top module: `pmic_regfile`

## Requirements
- R1: A read of index 0x00 returns 0x0215, with bit 7 also set (0x0295) while `variant_sel` is high. Writes to index 0x00 change nothing.
- R2: A write to index 0x01 XORs the write data into the interrupt status register. A read of index 0x01 returns the interrupt status.
- R3: The interrupt mask at index 0x02 is read/write and resets to 0xFFFF. `irq_out` is high exactly when some bit is set in the interrupt status and clear in the mask.
- R4: A write to index 0x08 selects the converter channel from write-data bits 13:10, ignores the other bits, and sets interrupt status bit 8.
- R5: A read of index 0x08 returns the selected channel in bits 13:10 and that channel's 10-bit result in bits 9:0. The results are fixed:
  - ch1 0x3C2, ch2 0x0FC, ch3 0x165, ch4 0x07B, ch5 0x3FF
  - ch6 0x011, ch7 0x011, ch8 0x250
  - ch10 0x002, ch11 0x011, ch12 0x3D0, ch13 0x330
  - every other channel reads 0.
- R6: The sampling-control register at index 0x09 resets to 0xA5C3. A write clears every bit that is 1 in the write data and leaves the other bits unchanged.
- R7: `shutdown_req` rises in the cycle after a write of 0x0000 to index 0x17, but only while bit 1 of control register 0x0D is 1. It then stays high until reset. A nonzero watchdog write, or a zero write with that bit clear, has no effect.
- R8: The key status register at index 0x16 resets to 0x0020. A one-cycle `key_evt` pulse sets interrupt status bit 0. The same pulse clears status bit 5 when `key_down` is 1 and sets bit 5 when `key_down` is 0. A key event in the same cycle as a status write still leaves bit 0 set.
- R9: The calibration register at index 0x06 resets to 0x0001. It and the control registers at 0x0D and 0x0E (reset 0x0000) are plain read/write registers.
- R10: Indices 0x07 and 0x12 to 0x15 are undecoded. They read as 0, ignore writes, and pulse `bad_index` for one cycle. The other unmodeled slots (0x03 to 0x05, 0x0A to 0x0C, 0x0F to 0x11, 0x17 to 0x1F) read as 0 without an error.
- R11: `acc_rdata` takes the read value in the cycle after a read strobe and otherwise holds. It is 0x0000 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One-cycle access strobe from the bus slave |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_index | input | 5 | Register index |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data, valid the cycle after a read strobe |
| variant_sel | input | 1 | Selects the alternate identity value |
| key_evt | input | 1 | One-cycle power-key event |
| key_down | input | 1 | Key level at the event, 1 = pressed |
| irq_out | output | 1 | Level interrupt, unmasked status nonzero |
| shutdown_req | output | 1 | Sticky system shutdown request |
| bad_index | output | 1 | One-cycle pulse after an access to an undecoded index |

## Verification
The hardest state to reach is the watchdog shutdown. It needs three things in order: the enable bit written into control register 0x0D, a zero write to the watchdog index, and nonzero or unenabled watchdog writes beforehand that must leave the output low.

The stimulus builds this sequence step by step. It then confirms that the request survives later accesses and is cleared only by reset. The interrupt path is driven the same way: a converter select sets status bit 8 while the mask still hides it, and mask writes afterwards reveal it and hide it again at `irq_out`.

// File: rtl/pmic_pkg.sv
package pmic_pkg;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 5;
    localparam int CH_W   = 4;
    localparam int RES_W  = 10;

    localparam logic [IDX_W-1:0] IX_ID     = 5'h00;
    localparam logic [IDX_W-1:0] IX_ISTAT  = 5'h01;
    localparam logic [IDX_W-1:0] IX_IMASK  = 5'h02;
    localparam logic [IDX_W-1:0] IX_CAL    = 5'h06;
    localparam logic [IDX_W-1:0] IX_ADC    = 5'h08;
    localparam logic [IDX_W-1:0] IX_SAMPLE = 5'h09;
    localparam logic [IDX_W-1:0] IX_CTRL1  = 5'h0D;
    localparam logic [IDX_W-1:0] IX_CTRL2  = 5'h0E;
    localparam logic [IDX_W-1:0] IX_KEYST  = 5'h16;
    localparam logic [IDX_W-1:0] IX_WDOG   = 5'h17;

    typedef struct packed {
        logic [DATA_W-1:0] irq_stat;
        logic [DATA_W-1:0] irq_mask;
        logic [DATA_W-1:0] cal;
        logic [DATA_W-1:0] ctrl1;
        logic [DATA_W-1:0] ctrl2;
        logic [DATA_W-1:0] sample;
        logic [DATA_W-1:0] key_stat;
        logic [CH_W-1:0]   adc_ch;
        logic [DATA_W-1:0] rdata;
        logic              err;
        logic              shutdown;
    } pm_state_t;
endpackage

// File: rtl/pm_index_decode.sv
module pm_index_decode #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] index,
    output logic             undecoded
);
    localparam int NUM_IDX = 1 << IDX_W;

    logic [NUM_IDX-1:0] bad_vec;

    for (genvar i = 0; i < NUM_IDX; i++) begin : g_idx
        // Slot 7 and the band 0x12..0x15 have no register behind them.
        assign bad_vec[i] = (i == 7) || (i >= 18 && i <= 21);
    end

    assign undecoded = bad_vec[index];
endmodule

// File: rtl/pm_adc_table.sv
module pm_adc_table #(
    parameter int CH_W  = 4,
    parameter int RES_W = 10
) (
    input  logic [CH_W-1:0]  channel,
    output logic [RES_W-1:0] result
);
    function automatic logic [RES_W-1:0] preset(input int ch);
        case (ch)
            1:       preset = RES_W'(10'h3C2);
            2:       preset = RES_W'(10'h0FC);
            3:       preset = RES_W'(10'h165);
            4:       preset = RES_W'(10'h07B);
            5:       preset = RES_W'(10'h3FF);
            6, 7:    preset = RES_W'(10'h011);
            8:       preset = RES_W'(10'h250);
            10:      preset = RES_W'(10'h002);
            11:      preset = RES_W'(10'h011);
            12:      preset = RES_W'(10'h3D0);
            13:      preset = RES_W'(10'h330);
            default: preset = '0;
        endcase
    endfunction

    localparam int NUM_CH = 1 << CH_W;

    logic [RES_W-1:0] table_q [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign table_q[c] = preset(c);
    end

    assign result = table_q[channel];
endmodule

// File: rtl/pm_read_mux.sv
module pm_read_mux
    import pmic_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_VALUE    = 16'h0215,
    parameter int                VARIANT_BIT = 7
) (
    input  logic [IDX_W-1:0]  index,
    input  logic              variant_sel,
    input  pm_state_t         st,
    input  logic [RES_W-1:0]  adc_result,
    output logic [DATA_W-1:0] rd_value
);
    localparam int PAD_W = DATA_W - CH_W - RES_W;

    always_comb begin
        rd_value = '0;
        case (index)
            IX_ID: begin
                rd_value = ID_VALUE;
                rd_value[VARIANT_BIT] = rd_value[VARIANT_BIT] | variant_sel;
            end
            IX_ISTAT:  rd_value = st.irq_stat;
            IX_IMASK:  rd_value = st.irq_mask;
            IX_CAL:    rd_value = st.cal;
            IX_ADC:    rd_value = {{PAD_W{1'b0}}, st.adc_ch, adc_result};
            IX_SAMPLE: rd_value = st.sample;
            IX_CTRL1:  rd_value = st.ctrl1;
            IX_CTRL2:  rd_value = st.ctrl2;
            IX_KEYST:  rd_value = st.key_stat;
            default:   rd_value = '0;
        endcase
    end
endmodule

// File: rtl/pmic_regfile.sv
module pmic_regfile
    import pmic_pkg::*;
#(
    parameter logic [DATA_W-1:0] SAMPLE_RST  = 16'hA5C3,
    parameter logic [DATA_W-1:0] KEYST_RST   = 16'h0020,
    parameter logic [DATA_W-1:0] CAL_RST     = 16'h0001,
    parameter int                KEY_BIT     = 5,
    parameter int                IRQ_KEY     = 0,
    parameter int                IRQ_ADC     = 8,
    parameter int                WDOG_EN_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [IDX_W-1:0]  acc_index,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic              variant_sel,
    input  logic              key_evt,
    input  logic              key_down,
    output logic              irq_out,
    output logic              shutdown_req,
    output logic              bad_index
);
    localparam int CH_LSB = RES_W;

    pm_state_t state_d, state_q;

    logic              undecoded;
    logic [CH_W-1:0]   sel_ch;
    logic [RES_W-1:0]  adc_result;
    logic [DATA_W-1:0] rd_value;
    logic [DATA_W-1:0] irq_stat_q;

    pm_index_decode #(.IDX_W(IDX_W)) u_dec (
        .index     (acc_index),
        .undecoded (undecoded)
    );

    assign sel_ch = state_q.adc_ch;

    pm_adc_table #(.CH_W(CH_W), .RES_W(RES_W)) u_adc (
        .channel (sel_ch),
        .result  (adc_result)
    );

    pm_read_mux u_rmux (
        .index       (acc_index),
        .variant_sel (variant_sel),
        .st          (state_q),
        .adc_result  (adc_result),
        .rd_value    (rd_value)
    );

    always_comb begin
        state_d = state_q;
        state_d.err = 1'b0;
        if (acc_valid) begin
            if (undecoded) begin
                state_d.err = 1'b1;
            end else if (acc_write) begin
                case (acc_index)
                    IX_ISTAT:  state_d.irq_stat = state_q.irq_stat ^ acc_wdata;
                    IX_IMASK:  state_d.irq_mask = acc_wdata;
                    IX_CAL:    state_d.cal = acc_wdata;
                    IX_ADC: begin
                        state_d.adc_ch = acc_wdata[CH_LSB +: CH_W];
                        state_d.irq_stat[IRQ_ADC] = 1'b1;
                    end
                    IX_SAMPLE: state_d.sample = state_q.sample & ~acc_wdata;
                    IX_CTRL1:  state_d.ctrl1 = acc_wdata;
                    IX_CTRL2:  state_d.ctrl2 = acc_wdata;
                    IX_WDOG: begin
                        if (acc_wdata == '0 && state_q.ctrl1[WDOG_EN_BIT])
                            state_d.shutdown = 1'b1;
                    end
                    default: ;
                endcase
            end
            if (!acc_write)
                state_d.rdata = undecoded ? '0 : rd_value;
        end
        if (key_evt) begin
            state_d.irq_stat[IRQ_KEY] = 1'b1;
            state_d.key_stat[KEY_BIT] = ~key_down;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q          <= '0;
            state_q.irq_mask <= '1;
            state_q.cal      <= CAL_RST;
            state_q.sample   <= SAMPLE_RST;
            state_q.key_stat <= KEYST_RST;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_stat_q   = state_q.irq_stat;
    assign acc_rdata    = state_q.rdata;
    assign irq_out      = |(state_q.irq_stat & ~state_q.irq_mask);
    assign shutdown_req = state_q.shutdown;
    assign bad_index    = state_q.err;
endmodule

module pmic_regfile_chk
    import pmic_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [IDX_W-1:0]  acc_index,
    input logic [DATA_W-1:0] acc_wdata,
    input logic [DATA_W-1:0] acc_rdata,
    input logic              variant_sel,
    input logic              key_evt,
    input logic              irq_out,
    input logic              shutdown_req,
    input logic              bad_index,
    input logic [DATA_W-1:0] irq_stat_q
);
    logic hole;
    assign hole = (acc_index == 5'h07) || (acc_index >= 5'h12 && acc_index <= 5'h15);

    // R1
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write && acc_index == IX_ID |=>
        acc_rdata == ($past(variant_sel) ? 16'h0295 : 16'h0215));

    // R2
    stat_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write && acc_index == IX_ISTAT && !key_evt |=>
        irq_stat_q == ($past(irq_stat_q) ^ $past(acc_wdata)));

    // R3
    full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write && acc_index == IX_IMASK && acc_wdata == 16'hFFFF |=> !irq_out);

    // R7
    shutdown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> shutdown_req);

    // R7
    shutdown_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_req) |-> $past(acc_valid && acc_write && acc_index == IX_WDOG && acc_wdata == 16'h0000));

    // R8
    key_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_evt |=> irq_stat_q[0]);

    // R10
    hole_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && hole |=> bad_index);

    // R10
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_index |-> $past(acc_valid && hole));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> $stable(acc_rdata));
endmodule

bind pmic_regfile pmic_regfile_chk u_chk (.*);

// File: tb/tb_pmic_regfile.sv
`timescale 1ns/1ps
module tb_pmic_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [4:0]  acc_index = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic        variant_sel = 1'b0;
    logic        key_evt = 1'b0;
    logic        key_down = 1'b0;
    logic        irq_out;
    logic        shutdown_req;
    logic        bad_index;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pmic_regfile dut (.*);

    // {write, index, wdata, expected read}
    localparam int NV = 34;
    localparam logic [37:0] VEC [NV] = '{
        {1'b0, 5'h00, 16'h0000, 16'h0215},  // R1
        {1'b0, 5'h02, 16'h0000, 16'hFFFF},  // R3
        {1'b0, 5'h16, 16'h0000, 16'h0020},  // R8
        {1'b0, 5'h06, 16'h0000, 16'h0001},  // R9
        {1'b1, 5'h06, 16'h1234, 16'h0000},
        {1'b0, 5'h06, 16'h0000, 16'h1234},  // R9
        {1'b1, 5'h0D, 16'h00A0, 16'h0000},
        {1'b0, 5'h0D, 16'h0000, 16'h00A0},  // R9
        {1'b1, 5'h0E, 16'hBEEF, 16'h0000},
        {1'b0, 5'h0E, 16'h0000, 16'hBEEF},  // R9
        {1'b1, 5'h01, 16'h0005, 16'h0000},
        {1'b0, 5'h01, 16'h0000, 16'h0005},  // R2
        {1'b1, 5'h01, 16'h0104, 16'h0000},
        {1'b0, 5'h01, 16'h0000, 16'h0101},  // R2
        {1'b1, 5'h01, 16'h0101, 16'h0000},
        {1'b1, 5'h08, 16'h2000, 16'h0000},
        {1'b0, 5'h01, 16'h0000, 16'h0100},  // R4
        {1'b0, 5'h08, 16'h0000, 16'h2250},  // R5
        {1'b1, 5'h08, 16'h0400, 16'h0000},
        {1'b0, 5'h08, 16'h0000, 16'h07C2},  // R5
        {1'b1, 5'h08, 16'h3400, 16'h0000},
        {1'b0, 5'h08, 16'h0000, 16'h3730},  // R5
        {1'b1, 5'h08, 16'h2400, 16'h0000},
        {1'b0, 5'h08, 16'h0000, 16'h2400},  // R5
        {1'b1, 5'h08, 16'hC7FF, 16'h0000},
        {1'b0, 5'h08, 16'h0000, 16'h07C2},  // R4
        {1'b0, 5'h09, 16'h0000, 16'hA5C3},  // R6
        {1'b1, 5'h09, 16'h8001, 16'h0000},
        {1'b0, 5'h09, 16'h0000, 16'h25C2},  // R6
        {1'b1, 5'h00, 16'hFFFF, 16'h0000},
        {1'b0, 5'h00, 16'h0000, 16'h0215},  // R1
        {1'b1, 5'h12, 16'hFFFF, 16'h0000},
        {1'b0, 5'h12, 16'h0000, 16'h0000},  // R10
        {1'b0, 5'h1F, 16'h0000, 16'h0000}   // R10
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [4:0] idx, input logic [15:0] wd);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_write = wr;
        acc_index = idx;
        acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
    endtask

    task automatic key(input logic down);
        @(negedge clk);
        key_evt  = 1'b1;
        key_down = down;
        @(negedge clk);
        key_evt  = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset rdata", acc_rdata, 16'h0000);
        check("R3 reset irq", {15'd0, irq_out}, 16'h0000);
        check("R7 reset shutdown", {15'd0, shutdown_req}, 16'h0000);
        check("R10 reset flag", {15'd0, bad_index}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][37], VEC[i][36:32], VEC[i][31:16]);
            if (!VEC[i][37])
                check($sformatf("vector %0d", i), acc_rdata, VEC[i][15:0]);
        end

        // R11: rdata holds across writes
        access(1'b1, 5'h0E, 16'h0001);
        check("R11 hold", acc_rdata, 16'h0000);

        // R3: status bit 8 is set, fully masked so far
        check("R3 masked", {15'd0, irq_out}, 16'h0000);
        access(1'b1, 5'h02, 16'hFEFF);
        check("R3 unmasked", {15'd0, irq_out}, 16'h0001);
        access(1'b1, 5'h02, 16'hFFFF);
        check("R3 remasked", {15'd0, irq_out}, 16'h0000);

        // R8: key events
        access(1'b1, 5'h01, 16'h0100);
        key(1'b1);
        access(1'b0, 5'h16, 16'h0000);
        check("R8 pressed", acc_rdata, 16'h0000);
        access(1'b0, 5'h01, 16'h0000);
        check("R8 key irq", acc_rdata, 16'h0001);
        key(1'b0);
        access(1'b0, 5'h16, 16'h0000);
        check("R8 released", acc_rdata, 16'h0020);
        access(1'b1, 5'h02, 16'hFFFE);
        check("R8 key irq out", {15'd0, irq_out}, 16'h0001);
        // R8: key event together with a toggle write of bit 0
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_index = 5'h01; acc_wdata = 16'h0001;
        key_evt = 1'b1; key_down = 1'b0;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; key_evt = 1'b0;
        access(1'b0, 5'h01, 16'h0000);
        check("R8 key beats toggle", acc_rdata, 16'h0001);

        // R10: error flag pulse
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_index = 5'h13;
        @(negedge clk);
        acc_valid = 1'b0;
        check("R10 flag pulse", {15'd0, bad_index}, 16'h0001);
        @(negedge clk);
        check("R10 flag clears", {15'd0, bad_index}, 16'h0000);
        access(1'b0, 5'h07, 16'h0000);
        check("R10 slot 7 flag", {15'd0, bad_index}, 16'h0001);
        access(1'b0, 5'h18, 16'h0000);
        check("R10 modeled slot no flag", {15'd0, bad_index}, 16'h0000);

        // R1: variant identity
        variant_sel = 1'b1;
        access(1'b0, 5'h00, 16'h0000);
        check("R1 variant id", acc_rdata, 16'h0295);
        variant_sel = 1'b0;

        // R7: watchdog sequence
        access(1'b1, 5'h17, 16'h0000);
        check("R7 not enabled", {15'd0, shutdown_req}, 16'h0000);
        access(1'b1, 5'h0D, 16'h0002);
        access(1'b1, 5'h17, 16'h0005);
        check("R7 nonzero write", {15'd0, shutdown_req}, 16'h0000);
        access(1'b1, 5'h17, 16'h0000);
        check("R7 shutdown", {15'd0, shutdown_req}, 16'h0001);
        access(1'b1, 5'h0D, 16'h0000);
        access(1'b0, 5'h17, 16'h0000);
        check("R7 sticky", {15'd0, shutdown_req}, 16'h0001);
        check("R10 watchdog reads zero", acc_rdata, 16'h0000);

        // Reset again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R7 cleared by reset", {15'd0, shutdown_req}, 16'h0000);
        access(1'b0, 5'h02, 16'h0000);
        check("R3 mask after reset", acc_rdata, 16'hFFFF);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule